// File: doc/BRIEF.md
# SPI Addressed Command Front-End

This block is the serial slave side of a four-channel register device. It watches a chip-select, a serial clock, a serial data input, a pause (hold) input and a write-protect input. It oversamples all of them in a fast system clock domain. After chip select falls, the first byte received must name this device: a fixed type code plus the value on two address strap pins. Up to four such devices can therefore share one bus. The second byte is decoded into an opcode, a register pointer and a channel pointer, and these are handed to a register bank with a one-cycle strobe.

Every later byte of the same transaction is passed to the bank as a write byte. For a read opcode, the block shifts the bank's read data back out on its serial output. The pause input freezes the transfer mid-byte without losing the bit position. The write-protect level is forwarded to the bank after synchronisation. A device that is not addressed, or a transfer cut short by chip select, produces no strobe.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, no transaction opens until the synchronised chip select has been seen high and then low; chip select held low through reset release opens nothing.
- R2: The serial input is sampled on rising serial clock edges, most significant bit first; eight counted rising edges make one byte, and each strobe rises one system clock after the synchronised eighth edge.
- R3: The first byte must equal type code 0101 in bits 7..4, zeros in bits 3..2 and the strap value in bits 1..0; on any mismatch no cmd_valid or data_valid is raised until chip select goes high.
- R4: The second byte raises cmd_valid for exactly one cycle, with cmd_op = bits 7..4, cmd_reg = bits 3..2 and cmd_chan = bits 1..0; the fields hold until the next command.
- R5: Every further complete byte of an addressed transaction raises data_valid for one cycle, with the byte on data_byte.
- R6: An opcode whose bit 3 (byte bit 7) is 1 is a read. After its instruction byte, rd_data is shifted out on miso most significant bit first, and each bit changes on a falling serial clock edge. The first falling edge after the instruction byte presents bit 7.
- R7: miso_oe is low out of reset, while deselected, during the identification and instruction bytes, for non-read opcodes, for unaddressed transactions and while paused.
- R8: The pause state is entered when hold_n is seen low while the serial clock is low, and is left when hold_n is seen high while the serial clock is low. Clock edges during the pause are ignored, and the bit count and shift contents survive it.
- R9: Chip select rising before a byte completes discards the partial byte with no strobe, and the next transaction starts from bit zero.
- R10: wr_protect is the inverse of the synchronised wp_n level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low write-protect level |
| addr_strap | input | ADDR_W (2) | Strapped device address |
| rd_data | input | 8 | Read byte supplied by the register bank |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for miso (low means released) |
| cmd_valid | output | 1 | One-cycle strobe for a decoded instruction byte |
| cmd_op | output | OP_W (4) | Decoded opcode |
| cmd_reg | output | REG_W (2) | Decoded register pointer |
| cmd_chan | output | CH_W (2) | Decoded channel pointer |
| data_valid | output | 1 | One-cycle strobe for a received data byte |
| data_byte | output | 8 | Received data byte |
| wr_protect | output | 1 | Write protection active, forwarded to the bank |

## Verification
The assertions check several properties on every cycle. Command strobes never last two cycles and never coincide with data strobes. An unaddressed or just-deselected transaction is silent. The output enable is only ever set for a read in the data phase. The pause flag moves only while the serial clock is low, and the bit count stays frozen during a pause. Other behaviour can only be shown by the bench's scenarios against its cycle model. These are the correct field and byte values, the most-significant-first order of read data, the rejection of wrong type, padding and strap values, the discarding of truncated bytes, and the survival of a transfer across a pause.

// File: rtl/spi_cfe_pkg.sv
package spi_cfe_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ID,
      PH_INSTR,
      PH_DATA,
      PH_IGNORE
   } phase_t;
endpackage

// File: rtl/spi_cfe_sync.sv
module spi_cfe_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_cfe_events.sv
module spi_cfe_events (
   input  logic clk,
   input  logic rst_n,
   input  logic s_sck,
   input  logic s_cs_n,
   input  logic s_hold_n,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_fall,
   output logic cs_rise,
   output logic held
);
   logic sck_d, cs_d;

   assign cs_fall  = ~s_cs_n & cs_d;
   assign cs_rise  = s_cs_n & ~cs_d;
   assign sck_rise = s_sck & ~sck_d & ~held;
   assign sck_fall = ~s_sck & sck_d & ~held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b0;
         held  <= 1'b0;
      end else begin
         sck_d <= s_sck;
         cs_d  <= s_cs_n;
         if (cs_fall || cs_rise) held <= 1'b0;
         else if (!s_sck)        held <= ~s_hold_n;
      end
   end

   // R8: pause state only moves while the serial clock is low
   a_r8_hold_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sck && !cs_fall && !cs_rise) |=> $stable(held));
endmodule

// File: rtl/spi_cfe_rx.sv
module spi_cfe_rx #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              din,
   output logic [CNT_W-1:0]  cnt,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_nxt
);
   logic [BYTE_W-2:0] sh;

   assign byte_nxt  = {sh, din};
   assign byte_done = shift_en && !clr && (cnt == CNT_W'(BYTE_W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (clr) begin
         sh  <= '0;
         cnt <= '0;
      end else if (shift_en) begin
         sh  <= byte_nxt[BYTE_W-2:0];
         cnt <= (cnt == CNT_W'(BYTE_W-1)) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/spi_cfe_tx.sv
module spi_cfe_tx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              load,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              bit_out,
   output logic              live
);
   logic [BYTE_W-2:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         bit_out <= 1'b0;
         live    <= 1'b0;
      end else if (clr) begin
         sh      <= '0;
         bit_out <= 1'b0;
         live    <= 1'b0;
      end else if (shift_en) begin
         live <= 1'b1;
         if (load) begin
            bit_out <= rd_data[BYTE_W-1];
            sh      <= rd_data[BYTE_W-2:0];
         end else begin
            bit_out <= sh[BYTE_W-2];
            sh      <= {sh[BYTE_W-3:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
   import spi_cfe_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter int               TYPE_W      = 4,
   parameter logic [TYPE_W-1:0] TYPE_CODE  = 4'b0101,
   parameter int               ADDR_W      = 2,
   parameter int               NUM_REGS    = 4,
   parameter int               NUM_CHANS   = 4,
   parameter int               OP_W        = 4,
   localparam int              REG_W       = $clog2(NUM_REGS),
   localparam int              CH_W        = $clog2(NUM_CHANS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              mosi,
   input  logic              hold_n,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] addr_strap,
   input  logic [7:0]        rd_data,
   output logic              miso,
   output logic              miso_oe,
   output logic              cmd_valid,
   output logic [OP_W-1:0]   cmd_op,
   output logic [REG_W-1:0]  cmd_reg,
   output logic [CH_W-1:0]   cmd_chan,
   output logic              data_valid,
   output logic [7:0]        data_byte,
   output logic              wr_protect
);
   localparam int PAD_W = BYTE_W - TYPE_W - ADDR_W;
   localparam int CNT_W = $clog2(BYTE_W);

   generate
      if (PAD_W < 1) begin : g_chk_id
         $error("identification byte needs at least one padding bit");
      end
      if (OP_W + REG_W + CH_W != BYTE_W) begin : g_chk_instr
         $error("instruction fields must fill exactly one byte");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_chk_sync
         $error("SYNC_STAGES out of range 0..4");
      end
   endgenerate

   logic [4:0] pin_vec, syn_vec;
   logic s_cs_n, s_sck, s_mosi, s_hold_n, s_wp_n;
   logic sck_rise, sck_fall, cs_fall, cs_rise, held, cs_evt;
   logic [CNT_W-1:0]  rx_cnt;
   logic              byte_done;
   logic [BYTE_W-1:0] byte_nxt;
   logic              rx_shift, tx_shift, tx_live, is_read, id_ok;
   logic [BYTE_W-1:0] id_exp;
   phase_t            phase;

   assign pin_vec = {wp_n, hold_n, mosi, sck, cs_n};

   spi_cfe_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11000)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_vec), .q(syn_vec));

   assign s_cs_n   = syn_vec[0];
   assign s_sck    = syn_vec[1];
   assign s_mosi   = syn_vec[2];
   assign s_hold_n = syn_vec[3];
   assign s_wp_n   = syn_vec[4];

   spi_cfe_events u_evt (
      .clk(clk), .rst_n(rst_n), .s_sck(s_sck), .s_cs_n(s_cs_n), .s_hold_n(s_hold_n),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .held(held));

   assign cs_evt   = cs_fall | cs_rise;
   assign rx_shift = sck_rise && (phase == PH_ID || phase == PH_INSTR || phase == PH_DATA);

   spi_cfe_rx #(.BYTE_W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(cs_evt), .shift_en(rx_shift), .din(s_mosi),
      .cnt(rx_cnt), .byte_done(byte_done), .byte_nxt(byte_nxt));

   assign id_exp = {TYPE_CODE, {PAD_W{1'b0}}, addr_strap};
   assign id_ok  = (byte_nxt == id_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         is_read    <= 1'b0;
         cmd_valid  <= 1'b0;
         cmd_op     <= '0;
         cmd_reg    <= '0;
         cmd_chan   <= '0;
         data_valid <= 1'b0;
         data_byte  <= '0;
      end else begin
         cmd_valid  <= 1'b0;
         data_valid <= 1'b0;
         if (cs_rise) begin
            phase   <= PH_IDLE;
            is_read <= 1'b0;
         end else if (cs_fall) begin
            phase   <= PH_ID;
            is_read <= 1'b0;
         end else if (byte_done) begin
            case (phase)
               PH_ID:    phase <= id_ok ? PH_INSTR : PH_IGNORE;
               PH_INSTR: begin
                  phase     <= PH_DATA;
                  cmd_valid <= 1'b1;
                  cmd_op    <= byte_nxt[BYTE_W-1 -: OP_W];
                  cmd_reg   <= byte_nxt[CH_W +: REG_W];
                  cmd_chan  <= byte_nxt[0 +: CH_W];
                  is_read   <= byte_nxt[BYTE_W-1];
               end
               PH_DATA: begin
                  data_valid <= 1'b1;
                  data_byte  <= byte_nxt;
               end
               default: ;
            endcase
         end
      end
   end

   assign tx_shift = sck_fall && (phase == PH_DATA) && is_read;

   spi_cfe_tx #(.BYTE_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(cs_evt), .shift_en(tx_shift),
      .load(rx_cnt == '0), .rd_data(rd_data), .bit_out(miso), .live(tx_live));

   assign miso_oe    = tx_live & ~held;
   assign wr_protect = ~s_wp_n;

   // R4: command strobe lasts a single cycle
   a_r4_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);
   // R2: a completed byte is either a command or a data byte, never both
   a_r2_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, data_valid}));
   // R3: unaddressed transaction stays silent
   a_r3_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGNORE) |=> (!cmd_valid && !data_valid));
   // R9: deselect discards a partial byte
   a_r9_no_strobe_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (!cmd_valid && !data_valid));
   // R7: output released outside a read data phase
   a_r7_oe_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_DATA) |-> !miso_oe);
   // R6: only read opcodes drive the output
   a_r6_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> is_read);
   // R8: bit position frozen during a pause
   a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !cs_evt) |=> $stable(rx_cnt));
endmodule

// File: tb/spi_cmd_frontend_bench.sv
`timescale 1ns/1ps
module spi_cmd_frontend_bench;
   localparam int SYNC = 2;
   localparam int HALF = 6;
   localparam int P_IDLE = 0, P_ID = 1, P_INSTR = 2, P_DATA = 3, P_IGN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic [1:0] addr_strap = 2'b01;
   logic [7:0] rd_val = 8'h00;
   logic miso, miso_oe, cmd_valid, data_valid, wr_protect;
   logic [3:0] cmd_op;
   logic [1:0] cmd_reg, cmd_chan;
   logic [7:0] data_byte;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   spi_cmd_frontend #(.SYNC_STAGES(SYNC)) u_spi_cmd_frontend (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
      .wp_n(wp_n), .addr_strap(addr_strap), .rd_data(rd_val), .miso(miso),
      .miso_oe(miso_oe), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
      .cmd_chan(cmd_chan), .data_valid(data_valid), .data_byte(data_byte),
      .wr_protect(wr_protect));

   // ---------------- behavioural cycle model ----------------
   bit q_sck [SYNC], q_cs [SYNC], q_mo [SYNC], q_hd [SYNC], q_wp [SYNC];
   bit m_sckd, m_csd, m_held, m_isrd, m_cv, m_dv, m_live, m_bit;
   int m_phase, m_cnt;
   bit [7:0] m_acc, m_tx, m_db;
   bit [3:0] m_op;
   bit [1:0] m_reg, m_ch;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC; i++) begin
            q_sck[i] = 0; q_cs[i] = 0; q_mo[i] = 0; q_hd[i] = 1; q_wp[i] = 1;
         end
         m_sckd = 0; m_csd = 0; m_held = 0; m_isrd = 0; m_cv = 0; m_dv = 0;
         m_live = 0; m_bit = 0; m_phase = P_IDLE; m_cnt = 0; m_acc = 0; m_tx = 0;
         m_db = 0; m_op = 0; m_reg = 0; m_ch = 0;
      end else begin
         bit ss, scs, smo, shd, csf, csr, cse, rise, fall, done, o_isrd;
         int o_cnt, o_phase;
         ss = q_sck[SYNC-1]; scs = q_cs[SYNC-1]; smo = q_mo[SYNC-1]; shd = q_hd[SYNC-1];
         csf = !scs && m_csd; csr = scs && !m_csd; cse = csf || csr;
         rise = ss && !m_sckd && !m_held;
         fall = !ss && m_sckd && !m_held;
         o_cnt = m_cnt; o_phase = m_phase; o_isrd = m_isrd;
         m_cv = 0; m_dv = 0; done = 0;
         if (cse) begin
            m_cnt = 0; m_acc = 0;
         end else if (rise && (o_phase == P_ID || o_phase == P_INSTR || o_phase == P_DATA)) begin
            m_acc = {m_acc[6:0], smo};
            m_cnt++;
            if (m_cnt == 8) begin done = 1; m_cnt = 0; end
         end
         if (csr) begin m_phase = P_IDLE; m_isrd = 0; end
         else if (csf) begin m_phase = P_ID; m_isrd = 0; end
         else if (done) begin
            if (o_phase == P_ID)
               m_phase = (m_acc == {4'b0101, 2'b00, addr_strap}) ? P_INSTR : P_IGN;
            else if (o_phase == P_INSTR) begin
               m_phase = P_DATA; m_cv = 1; m_op = m_acc[7:4]; m_reg = m_acc[3:2];
               m_ch = m_acc[1:0]; m_isrd = m_acc[7];
            end else if (o_phase == P_DATA) begin
               m_dv = 1; m_db = m_acc;
            end
         end
         if (cse) begin
            m_live = 0; m_bit = 0; m_tx = 0;
         end else if (fall && o_phase == P_DATA && o_isrd) begin
            m_live = 1;
            if (o_cnt == 0) begin m_bit = rd_val[7]; m_tx = {rd_val[6:0], 1'b0}; end
            else begin m_bit = m_tx[7]; m_tx = {m_tx[6:0], 1'b0}; end
         end
         if (cse) m_held = 0;
         else if (!ss) m_held = !shd;
         m_sckd = ss; m_csd = scs;
         for (int i = SYNC-1; i > 0; i--) begin
            q_sck[i] = q_sck[i-1]; q_cs[i] = q_cs[i-1]; q_mo[i] = q_mo[i-1];
            q_hd[i] = q_hd[i-1]; q_wp[i] = q_wp[i-1];
         end
         q_sck[0] = sck; q_cs[0] = cs_n; q_mo[0] = mosi; q_hd[0] = hold_n; q_wp[0] = wp_n;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 cmd_valid", cmd_valid, m_cv);
         if (m_cv) chk("R4 cmd fields", {cmd_op, cmd_reg, cmd_chan}, {m_op, m_reg, m_ch});
         chk("R5 data_valid", data_valid, m_dv);
         if (m_dv) chk("R5 data_byte", data_byte, m_db);
         chk("R7 miso_oe", miso_oe, m_live && !m_held);
         if (miso_oe && m_live && !m_held) chk("R6 miso", miso, m_bit);
         chk("R10 wr_protect", wr_protect, !q_wp[SYNC-1]);
      end
   end

   // directed observation of strobes
   int ncmd = 0;
   logic [7:0] last_cmd = 0;
   logic [7:0] dq [$];
   bit oe_seen = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid) begin ncmd++; last_cmd = {cmd_op, cmd_reg, cmd_chan}; end
         if (data_valid) dq.push_back(data_byte);
         if (miso_oe) oe_seen = 1;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] b, input int nbits, input int hold_at,
                       output logic [7:0] got);
      got = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         sck = 0; mosi = b[i];
         wait_cyc(HALF);
         if (i == hold_at) begin
            hold_n = 0;
            wait_cyc(HALF);
            chk("R8 oe released while paused", miso_oe, 1'b0);
            for (int k = 0; k < 3; k++) begin
               mosi = ~mosi; sck = 1; wait_cyc(HALF); sck = 0; wait_cyc(HALF);
            end
            mosi = b[i];
            hold_n = 1;
            wait_cyc(HALF);
         end
         got[i] = miso;
         sck = 1;
         wait_cyc(HALF);
      end
   endtask

   task automatic cs_begin();
      cs_n = 1; sck = 0; wait_cyc(HALF);
      cs_n = 0; wait_cyc(HALF);
   endtask

   task automatic cs_end();
      sck = 0; wait_cyc(HALF);
      cs_n = 1; wait_cyc(2 * HALF);
   endtask

   task automatic txn(input logic [7:0] id, input logic [7:0] ins, input logic [7:0] d0,
                      input int hold_ins, input int hold_dat, output logic [7:0] got);
      logic [7:0] junk;
      cs_begin();
      xfer(id, 8, -1, junk);
      xfer(ins, 8, hold_ins, junk);
      xfer(d0, 8, hold_dat, got);
      cs_end();
   endtask

   initial begin
      logic [7:0] got, junk;
      int c0;
      wait_cyc(5);
      rst_n = 1;
      wait_cyc(2);
      // reset state
      chk("R7 reset oe", miso_oe, 1'b0);
      chk("R4 reset cmd_valid", cmd_valid, 1'b0);
      chk("R5 reset data_valid", data_valid, 1'b0);

      // R1: cs low since reset, no falling edge seen
      xfer(8'b0101_0001, 8, -1, junk);
      xfer(8'b0010_0111, 8, -1, junk);
      xfer(8'h11, 8, -1, junk);
      wait_cyc(HALF);
      chk("R1 no command before first select", ncmd, 0);
      cs_end();

      // R4 R5 R2: addressed write
      dq.delete(); oe_seen = 0; c0 = ncmd;
      cs_begin();
      xfer(8'b0101_0001, 8, -1, junk);
      xfer(8'b0010_0111, 8, -1, junk);
      xfer(8'hA5, 8, -1, junk);
      xfer(8'h3C, 8, -1, junk);
      cs_end();
      chk("R4 one command", ncmd - c0, 1);
      chk("R2 R4 decoded op/reg/chan", last_cmd, 8'b0010_0111);
      chk("R5 two data bytes", dq.size(), 2);
      if (dq.size() == 2) begin
         chk("R5 first data byte", dq[0], 8'hA5);
         chk("R5 second data byte", dq[1], 8'h3C);
      end
      chk("R7 no drive on write", oe_seen, 1'b0);

      // R3: wrong type code, nonzero padding, wrong strap
      dq.delete(); c0 = ncmd;
      txn(8'b0110_0001, 8'b0011_0000, 8'h77, -1, -1, got);
      txn(8'b0101_1001, 8'b0011_0000, 8'h77, -1, -1, got);
      txn(8'b0101_0010, 8'b0011_0000, 8'h77, -1, -1, got);
      chk("R3 rejected ids raise no command", ncmd - c0, 0);
      chk("R3 rejected ids raise no data", dq.size(), 0);

      // R6: read
      rd_val = 8'hC6; oe_seen = 0; c0 = ncmd;
      txn(8'b0101_0001, 8'b1001_1000, 8'h00, -1, -1, got);
      chk("R6 read byte msb first", got, 8'hC6);
      chk("R6 output driven on read", oe_seen, 1'b1);
      chk("R4 read command fields", last_cmd, 8'b1001_1000);

      // R8: pause inside instruction and inside read data
      rd_val = 8'h5B; c0 = ncmd;
      txn(8'b0101_0001, 8'b1110_0110, 8'h00, 3, 5, got);
      chk("R8 command intact across pause", last_cmd, 8'b1110_0110);
      chk("R8 one command with pause", ncmd - c0, 1);
      chk("R8 read data intact across pause", got, 8'h5B);

      // R9: truncated instruction
      c0 = ncmd; dq.delete();
      cs_begin();
      xfer(8'b0101_0001, 8, -1, junk);
      xfer(8'b0100_1100, 5, -1, junk);
      cs_end();
      chk("R9 partial byte gives no command", ncmd - c0, 0);
      txn(8'b0101_0001, 8'b0111_0010, 8'h42, -1, -1, got);
      chk("R9 fresh start after truncation", last_cmd, 8'b0111_0010);
      chk("R9 data after truncation", (dq.size() == 1) ? dq[0] : 8'hFF, 8'h42);

      // R3: other strap value
      addr_strap = 2'b10; c0 = ncmd;
      txn(8'b0101_0001, 8'b0001_0101, 8'h00, -1, -1, got);
      chk("R3 old strap no longer matches", ncmd - c0, 0);
      txn(8'b0101_0010, 8'b0001_0101, 8'h00, -1, -1, got);
      chk("R3 new strap matches", last_cmd, 8'b0001_0101);

      // R10
      wp_n = 0; wait_cyc(5);
      chk("R10 protect active", wr_protect, 1'b1);
      wp_n = 1; wait_cyc(5);
      chk("R10 protect released", wr_protect, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule